// File: doc/BRIEF.md
# SPI FIFO, Interrupt and DMA Request Block

This block sits between a register bus and a serial shift engine of an SPI controller. It buffers outgoing words in a transmit FIFO that the engine drains, and incoming words in a receive FIFO that the engine fills and software (or a DMA channel) empties through a data register. Both FIFOs are 16 bits wide and have a depth fixed at build time to 32 or 64 entries.

From the two fill levels it derives a status word, a set of interrupt sources (level crossings, sticky overflow/underflow errors and a chip-select-inactive event), a single interrupt line, and two DMA request lines, each compared against its own programmable watermark. Turning the controller off empties both FIFOs at once. Threshold and watermark registers are locked while the controller is on.

Register map (word addresses on `reg_addr`): 0 control (bit 0 enable, bit 1 target mode), 1 TX interrupt threshold, 2 RX interrupt threshold, 3 TX level, 4 RX level, 5 status, 6 interrupt mask, 7 masked interrupt status, 8 raw interrupt status, 9 interrupt clear, 10 DMA enables, 11 TX DMA watermark, 12 RX DMA watermark, 13 data (write pushes TX, read pops RX). Read data appears on `reg_rdata` one cycle after `reg_rd`.

Top module: `spi_fifo_ctrl`

## Requirements
- R1: The TX level (address 3) and RX level (address 4) read back as word counts; the TX FIFO holds exactly DEPTH words, and a data write to a full TX FIFO is dropped and sets raw interrupt bit 1 (TX overflow).
- R2: The status word (address 5) carries bit 0 engine busy, bit 1 TX full, bit 2 TX empty, bit 3 RX empty, bit 4 RX full, bit 5 target-transmit busy.
- R3: A data read from an empty RX FIFO returns 0 and sets raw bit 2 (RX underflow); an engine push into a full RX FIFO is dropped and sets raw bit 3 (RX overflow); RX words are read back in arrival order.
- R4: Raw status (address 8) has bit 0 TX level, bit 1 TX overflow, bit 2 RX underflow, bit 3 RX overflow, bit 4 RX level, bit 6 CS inactive; masked status (address 7) is raw AND mask (address 6), and `irq` is high one cycle after any masked bit is set.
- R5: Writing the clear register (address 9) with bit 0 clears all sticky flags, bit 1 clears RX underflow, bit 2 clears RX overflow, bit 3 clears TX overflow; other sticky flags stay set.
- R6: While enabled, raw bit 4 is set when the RX level exceeds the RX threshold, and raw bit 0 when the TX level is at or below the TX threshold; both are 0 while disabled.
- R7: DMA enables (address 10) use bit 1 for TX and bit 0 for RX; `tx_dma_req` is high while enabled and the TX level is at or below the TX watermark, `rx_dma_req` while the RX level is at least the RX watermark plus one; each follows one cycle behind.
- R8: Clearing control bit 0 empties both FIFOs on the next cycle; data writes and engine pushes made while disabled are dropped.
- R9: Registers 1, 2, 11 and 12 accept writes only while disabled; writes while enabled leave them unchanged.
- R10: With control bit 1 set, a low-to-high edge on `cs_n`, after a two-stage synchronizer, sets raw bit 6; with bit 1 clear the edge has no effect.
- R11: The TX FIFO presents words to the engine on `eng_tx_data` in the order they were written, with `eng_tx_valid` high while it is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered read data |
| eng_tx_pop | input | 1 | Engine takes the TX head word |
| eng_tx_valid | output | 1 | TX FIFO not empty |
| eng_tx_data | output | DW | TX head word |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | DW | Received word |
| eng_busy | input | 1 | Engine busy indication |
| eng_tgt_busy | input | 1 | Engine target-transmit busy indication |
| cs_n | input | 1 | External chip select, active low, asynchronous |
| irq | output | 1 | Interrupt request |
| tx_dma_req | output | 1 | TX DMA request |
| rx_dma_req | output | 1 | RX DMA request |

## Verification
The bench builds the block with DEPTH of 32 and DW of 16, so filling either FIFO to the brim and one word past it takes only 33 transfers, bringing both overflow paths and the full status bits within easy reach. With these values the watermark and threshold comparisons are tested at a few levels on both sides of their crossing, and the flush, lock and chip-select edge paths are exercised against the same small depth.

// File: rtl/spi_fifo_ctrl_pkg.sv
package spi_fifo_ctrl_pkg;

  typedef enum logic [3:0] {
    A_CTRL  = 4'd0,
    A_TXTHR = 4'd1,
    A_RXTHR = 4'd2,
    A_TXLVL = 4'd3,
    A_RXLVL = 4'd4,
    A_STAT  = 4'd5,
    A_MASK  = 4'd6,
    A_MIS   = 4'd7,
    A_RAW   = 4'd8,
    A_CLR   = 4'd9,
    A_DMA   = 4'd10,
    A_TXWM  = 4'd11,
    A_RXWM  = 4'd12,
    A_DATA  = 4'd13
  } reg_addr_e;

  localparam int NIRQ = 7;

  localparam int IRQ_TXLVL = 0;
  localparam int IRQ_TXOV  = 1;
  localparam int IRQ_RXUNF = 2;
  localparam int IRQ_RXOV  = 3;
  localparam int IRQ_RXLVL = 4;
  localparam int IRQ_CSIN  = 6;

  // sticky flag slots inside the interrupt unit
  localparam int NSTICKY = 4;
  localparam int ST_TXOV  = 0;
  localparam int ST_RXUNF = 1;
  localparam int ST_RXOV  = 2;
  localparam int ST_CSIN  = 3;

endpackage

// File: rtl/sfc_fifo.sv
module sfc_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          ovf,
  output logic          unf
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          wr_ok, rd_ok;

  assign full  = (level == CW'(DEPTH));
  assign empty = (level == '0);
  assign wr_ok = push && !full  && !flush;
  assign rd_ok = pop  && !empty && !flush;
  assign ovf   = push && full  && !flush;
  assign unf   = pop  && empty && !flush;

  // storage: write port only, no reset, so it maps to RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wdata;
  end

  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) rptr <= rptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/sfc_cs_edge.sv
module sfc_cs_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  output logic rise
);

  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-1:0], cs_n};
  end

  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  assign rise = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/sfc_irq.sv
module sfc_irq
  import spi_fifo_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            tx_lvl_hit,
  input  logic            rx_lvl_hit,
  input  logic [NSTICKY-1:0] set_ev,
  input  logic            clr_valid,
  input  logic [3:0]      clr_bits,
  input  logic [NIRQ-1:0] mask,
  output logic [NIRQ-1:0] raw,
  output logic [NIRQ-1:0] masked,
  output logic            irq
);

  logic [NSTICKY-1:0] flag;
  logic [NSTICKY-1:0] clr_ev;

  always_comb begin
    clr_ev           = '0;
    if (clr_valid) begin
      clr_ev         = {NSTICKY{clr_bits[0]}};
      clr_ev[ST_RXUNF] = clr_bits[0] | clr_bits[1];
      clr_ev[ST_RXOV]  = clr_bits[0] | clr_bits[2];
      clr_ev[ST_TXOV]  = clr_bits[0] | clr_bits[3];
    end
  end

  // a new event in the same cycle as its clear wins
  for (genvar i = 0; i < NSTICKY; i++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (rst) flag[i] <= 1'b0;
      else     flag[i] <= (flag[i] & ~clr_ev[i]) | set_ev[i];
    end
  end

  always_comb begin
    raw            = '0;
    raw[IRQ_TXLVL] = tx_lvl_hit;
    raw[IRQ_TXOV]  = flag[ST_TXOV];
    raw[IRQ_RXUNF] = flag[ST_RXUNF];
    raw[IRQ_RXOV]  = flag[ST_RXOV];
    raw[IRQ_RXLVL] = rx_lvl_hit;
    raw[IRQ_CSIN]  = flag[ST_CSIN];
  end

  assign masked = raw & mask;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |masked;
  end

endmodule

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl
  import spi_fifo_ctrl_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int DW      = 16,
  parameter int AW      = 4,
  parameter int CS_SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          eng_tx_pop,
  output logic          eng_tx_valid,
  output logic [DW-1:0] eng_tx_data,
  input  logic          eng_rx_push,
  input  logic [DW-1:0] eng_rx_data,
  input  logic          eng_busy,
  input  logic          eng_tgt_busy,
  input  logic          cs_n,
  output logic          irq,
  output logic          tx_dma_req,
  output logic          rx_dma_req
);

  localparam int CW = $clog2(DEPTH) + 1;

  function automatic logic hit(input logic [AW-1:0] a, input reg_addr_e r);
    return a == AW'(r);
  endfunction

  function automatic logic [DW-1:0] zx(input logic [CW-1:0] v);
    return DW'(v);
  endfunction

  // ---------------- configuration registers ----------------
  logic            ctrl_en, ctrl_tgt;
  logic [CW-1:0]   tx_thr, rx_thr, tx_wm, rx_wm;
  logic [NIRQ-1:0] irq_mask;
  logic [1:0]      dma_ctl;
  logic            cfg_wr_ok;

  assign cfg_wr_ok = reg_wr && !ctrl_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en  <= 1'b0;
      ctrl_tgt <= 1'b0;
      tx_thr   <= '0;
      rx_thr   <= '0;
      tx_wm    <= '0;
      rx_wm    <= '0;
      irq_mask <= '0;
      dma_ctl  <= '0;
    end else begin
      if (reg_wr && hit(reg_addr, A_CTRL)) begin
        ctrl_en  <= reg_wdata[0];
        ctrl_tgt <= reg_wdata[1];
      end
      if (reg_wr && hit(reg_addr, A_MASK)) irq_mask <= reg_wdata[NIRQ-1:0];
      if (reg_wr && hit(reg_addr, A_DMA))  dma_ctl  <= reg_wdata[1:0];
      if (cfg_wr_ok && hit(reg_addr, A_TXTHR)) tx_thr <= reg_wdata[CW-1:0];
      if (cfg_wr_ok && hit(reg_addr, A_RXTHR)) rx_thr <= reg_wdata[CW-1:0];
      if (cfg_wr_ok && hit(reg_addr, A_TXWM))  tx_wm  <= reg_wdata[CW-1:0];
      if (cfg_wr_ok && hit(reg_addr, A_RXWM))  rx_wm  <= reg_wdata[CW-1:0];
    end
  end

  // ---------------- FIFOs ----------------
  logic          flush;
  logic          tx_push, rx_pop;
  logic [DW-1:0] rx_head;
  logic [CW-1:0] tx_level, rx_level;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_ovf, tx_unf_unused, rx_ovf, rx_unf;

  assign flush   = !ctrl_en;
  assign tx_push = reg_wr && hit(reg_addr, A_DATA);
  assign rx_pop  = reg_rd && hit(reg_addr, A_DATA);

  sfc_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txf (
    .clk   (clk),
    .rst   (rst),
    .flush (flush),
    .push  (tx_push),
    .wdata (reg_wdata),
    .pop   (eng_tx_pop),
    .rdata (eng_tx_data),
    .level (tx_level),
    .full  (tx_full),
    .empty (tx_empty),
    .ovf   (tx_ovf),
    .unf   (tx_unf_unused)
  );

  sfc_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxf (
    .clk   (clk),
    .rst   (rst),
    .flush (flush),
    .push  (eng_rx_push),
    .wdata (eng_rx_data),
    .pop   (rx_pop),
    .rdata (rx_head),
    .level (rx_level),
    .full  (rx_full),
    .empty (rx_empty),
    .ovf   (rx_ovf),
    .unf   (rx_unf)
  );

  assign eng_tx_valid = !tx_empty;

  // ---------------- chip select edge ----------------
  logic cs_rise;

  sfc_cs_edge #(.STAGES(CS_SYNC)) u_cs (
    .clk  (clk),
    .rst  (rst),
    .cs_n (cs_n),
    .rise (cs_rise)
  );

  // ---------------- interrupts ----------------
  logic               tx_lvl_hit, rx_lvl_hit;
  logic [NSTICKY-1:0] set_ev;
  logic [NIRQ-1:0]    raw_irq, mis_irq;
  logic               clr_valid;

  assign tx_lvl_hit = ctrl_en && (tx_level <= tx_thr);
  assign rx_lvl_hit = ctrl_en && (rx_level >  rx_thr);
  assign clr_valid  = reg_wr && hit(reg_addr, A_CLR);

  always_comb begin
    set_ev           = '0;
    set_ev[ST_TXOV]  = tx_ovf;
    set_ev[ST_RXUNF] = rx_unf;
    set_ev[ST_RXOV]  = rx_ovf;
    set_ev[ST_CSIN]  = cs_rise && ctrl_tgt;
  end

  sfc_irq u_irq (
    .clk        (clk),
    .rst        (rst),
    .tx_lvl_hit (tx_lvl_hit),
    .rx_lvl_hit (rx_lvl_hit),
    .set_ev     (set_ev),
    .clr_valid  (clr_valid),
    .clr_bits   (reg_wdata[3:0]),
    .mask       (irq_mask),
    .raw        (raw_irq),
    .masked     (mis_irq),
    .irq        (irq)
  );

  // ---------------- DMA requests ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_dma_req <= 1'b0;
      rx_dma_req <= 1'b0;
    end else begin
      tx_dma_req <= ctrl_en && dma_ctl[1] && (tx_level <= tx_wm);
      rx_dma_req <= ctrl_en && dma_ctl[0] &&
                    ({1'b0, rx_level} >= ({1'b0, rx_wm} + (CW+1)'(1)));
    end
  end

  // ---------------- read path ----------------
  logic [5:0]    status;
  logic [DW-1:0] rd_mux;

  assign status = {eng_tgt_busy, rx_full, rx_empty, tx_empty, tx_full, eng_busy};

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      AW'(A_CTRL):  rd_mux = DW'({ctrl_tgt, ctrl_en});
      AW'(A_TXTHR): rd_mux = zx(tx_thr);
      AW'(A_RXTHR): rd_mux = zx(rx_thr);
      AW'(A_TXLVL): rd_mux = zx(tx_level);
      AW'(A_RXLVL): rd_mux = zx(rx_level);
      AW'(A_STAT):  rd_mux = DW'(status);
      AW'(A_MASK):  rd_mux = DW'(irq_mask);
      AW'(A_MIS):   rd_mux = DW'(mis_irq);
      AW'(A_RAW):   rd_mux = DW'(raw_irq);
      AW'(A_DMA):   rd_mux = DW'(dma_ctl);
      AW'(A_TXWM):  rd_mux = zx(tx_wm);
      AW'(A_RXWM):  rd_mux = zx(rx_wm);
      AW'(A_DATA):  rd_mux = rx_empty ? '0 : rx_head;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
  parameter int DEPTH = 32,
  parameter int DW    = 16,
  parameter int AW    = 4,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          en,
  input logic [CW-1:0] tx_level,
  input logic [CW-1:0] rx_level,
  input logic [CW-1:0] tx_thr,
  input logic [6:0]    raw,
  input logic [6:0]    mask,
  input logic [1:0]    dma_ctl,
  input logic          irq,
  input logic          tx_dma_req
);

  localparam logic [AW-1:0] ADR_CLR  = AW'(9);
  localparam logic [AW-1:0] ADR_DATA = AW'(13);

  AST_TX_LEVEL_MAX: assert property (@(posedge clk) disable iff (rst)
    tx_level <= CW'(DEPTH)); // R1

  AST_RX_LEVEL_MAX: assert property (@(posedge clk) disable iff (rst)
    rx_level <= CW'(DEPTH)); // R3

  AST_RX_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (en && reg_rd && !reg_wr && reg_addr == ADR_DATA && rx_level == '0) |=> raw[2]); // R3

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (|(raw & mask)) |=> irq); // R4

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(|(raw & mask)) |=> !irq); // R4

  AST_TXOV_STICKY: assert property (@(posedge clk) disable iff (rst)
    (raw[1] && !(reg_wr && reg_addr == ADR_CLR && (reg_wdata[0] || reg_wdata[3]))) |=> raw[1]); // R5

  AST_TXDMA_GATED: assert property (@(posedge clk) disable iff (rst)
    !dma_ctl[1] |=> !tx_dma_req); // R7

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !en |=> (tx_level == '0 && rx_level == '0)); // R8

  AST_THR_LOCKED: assert property (@(posedge clk) disable iff (rst)
    en |=> $stable(tx_thr)); // R9

endmodule

bind spi_fifo_ctrl sfc_checker #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .en         (ctrl_en),
  .tx_level   (tx_level),
  .rx_level   (rx_level),
  .tx_thr     (tx_thr),
  .raw        (raw_irq),
  .mask       (irq_mask),
  .dma_ctl    (dma_ctl),
  .irq        (irq),
  .tx_dma_req (tx_dma_req)
);

// File: tb/spi_fifo_ctrl_test.sv
module spi_fifo_ctrl_test;

  localparam int DEPTH = 32;
  localparam int DW    = 16;
  localparam int AW    = 4;

  localparam logic [3:0] CTRL = 0, TXTHR = 1, RXTHR = 2, TXLVL = 3, RXLVL = 4,
                         STAT = 5, MASK = 6, MIS = 7, RAW = 8, CLR = 9,
                         DMA = 10, TXWM = 11, RXWM = 12, DATA = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          eng_tx_pop = 1'b0;
  logic          eng_tx_valid;
  logic [DW-1:0] eng_tx_data;
  logic          eng_rx_push = 1'b0;
  logic [DW-1:0] eng_rx_data = '0;
  logic          eng_busy = 1'b0, eng_tgt_busy = 1'b0;
  logic          cs_n = 1'b1;
  logic          irq, tx_dma_req, rx_dma_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  spi_fifo_ctrl #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) uut (
    .clk, .rst, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .eng_tx_pop, .eng_tx_valid, .eng_tx_data, .eng_rx_push, .eng_rx_data,
    .eng_busy, .eng_tgt_busy, .cs_n, .irq, .tx_dma_req, .rx_dma_req
  );

  // ---------------- scoreboard ----------------
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];
  logic          rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= reg_rd;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        errors++;
        $display("FAIL %s: read got %h expected %h", t, reg_rdata, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [DW-1:0] e, input string t);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic check_bit(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: got %b expected %b", t, act, e);
    end
  endtask

  task automatic eng_pop(input logic [DW-1:0] e, input string t);
    @(negedge clk);
    checks++;
    if (eng_tx_valid !== 1'b1 || eng_tx_data !== e) begin
      errors++;
      $display("FAIL %s: tx head got %h (valid %b) expected %h", t, eng_tx_data, eng_tx_valid, e);
    end
    eng_tx_pop = 1'b1;
    @(negedge clk);
    eng_tx_pop = 1'b0;
  endtask

  task automatic eng_push(input logic [DW-1:0] d);
    @(negedge clk);
    eng_rx_push = 1'b1; eng_rx_data = d;
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected end");
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);

    // reset state: empty FIFOs, no flags, outputs low
    rd(STAT, 16'h000C, "R2 reset status");
    rd(RAW,  16'h0000, "R6 reset raw disabled");
    check_bit(irq, 1'b0, "R4 reset irq");
    check_bit(tx_dma_req, 1'b0, "R7 reset tx dma");

    // configure while disabled
    wr(TXTHR, 3); wr(RXTHR, 1); wr(TXWM, 2); wr(RXWM, 3);
    wr(MASK, 16'h001E); wr(DMA, 16'h0003);
    wr(CTRL, 16'h0001);
    idle(2);
    check_bit(tx_dma_req, 1'b1, "R7 tx dma at empty");
    check_bit(rx_dma_req, 1'b0, "R7 rx dma below watermark");

    // locked thresholds
    wr(TXTHR, 9);
    rd(TXTHR, 16'd3, "R9 tx threshold locked");
    wr(RXWM, 0);
    rd(RXWM, 16'd3, "R9 rx watermark locked");

    // TX fill and ordering
    for (int i = 1; i <= 4; i++) wr(DATA, 16'hA000 + DW'(i));
    rd(TXLVL, 16'd4, "R1 tx level four");
    rd(RAW, 16'h0000, "R6 tx level above threshold");
    idle(1);
    check_bit(tx_dma_req, 1'b0, "R7 tx dma above watermark");
    eng_pop(16'hA001, "R11 first word");
    eng_pop(16'hA002, "R11 second word");
    idle(2);
    check_bit(tx_dma_req, 1'b1, "R7 tx dma at watermark");

    // RX level and DMA
    eng_push(16'hB001); eng_push(16'hB002);
    rd(RAW, 16'h0011, "R6 rx level above threshold");
    rd(MIS, 16'h0010, "R4 masked status");
    check_bit(irq, 1'b1, "R4 irq from masked rx level");
    check_bit(rx_dma_req, 1'b0, "R7 rx dma at two words");
    eng_push(16'hB003); eng_push(16'hB004);
    idle(1);
    check_bit(rx_dma_req, 1'b1, "R7 rx dma at watermark plus one");

    // RX drain in order, then underflow
    rd(DATA, 16'hB001, "R3 rx order 1");
    rd(DATA, 16'hB002, "R3 rx order 2");
    rd(DATA, 16'hB003, "R3 rx order 3");
    rd(DATA, 16'hB004, "R3 rx order 4");
    rd(DATA, 16'h0000, "R3 empty read returns zero");
    rd(RAW, 16'h0005, "R3 rx underflow flag");

    // TX overflow
    for (int i = 0; i < 30; i++) wr(DATA, 16'hC000 + DW'(i));
    rd(TXLVL, 16'd32, "R1 tx level full");
    rd(STAT, 16'h000A, "R2 tx full status");
    wr(DATA, 16'hDEAD);
    rd(TXLVL, 16'd32, "R1 overflow word dropped");
    rd(RAW, 16'h0006, "R1 tx overflow flag");
    eng_pop(16'hA003, "R11 old word 3");
    eng_pop(16'hA004, "R11 old word 4");
    for (int i = 0; i < 30; i++) eng_pop(16'hC000 + DW'(i), "R11 fill order");
    idle(1);
    check_bit(eng_tx_valid, 1'b0, "R11 tx drained");
    rd(RAW, 16'h0007, "R5 sticky flags persist");

    // RX overflow
    for (int i = 0; i < 33; i++) eng_push(16'hE000 + DW'(i));
    rd(RXLVL, 16'd32, "R3 rx level full");
    rd(STAT, 16'h0014, "R2 rx full status");
    rd(RAW, 16'h001F, "R3 rx overflow flag");

    // selective clears
    wr(CLR, 16'h0002);
    rd(RAW, 16'h001B, "R5 clear rx underflow only");
    wr(CLR, 16'h0008);
    rd(RAW, 16'h0019, "R5 clear tx overflow only");

    // chip-select edge: ignored in host mode, flagged in target mode
    @(negedge clk) cs_n = 1'b0; idle(4);
    @(negedge clk) cs_n = 1'b1; idle(5);
    rd(RAW, 16'h0019, "R10 no flag outside target mode");
    wr(CTRL, 16'h0003);
    @(negedge clk) cs_n = 1'b0; idle(4);
    @(negedge clk) cs_n = 1'b1; idle(5);
    rd(RAW, 16'h0059, "R10 cs inactive flag");
    wr(MASK, 16'h0040);
    rd(MIS, 16'h0040, "R4 masked cs inactive");

    // clear all
    wr(CLR, 16'h0001);
    rd(RAW, 16'h0011, "R5 clear all sticky");
    rd(MIS, 16'h0000, "R4 masked after clear");
    idle(1);
    check_bit(irq, 1'b0, "R4 irq drops");

    // disable flushes
    wr(CTRL, 16'h0000);
    rd(RXLVL, 16'd0, "R8 rx flushed");
    rd(RAW, 16'h0000, "R6 level bits off when disabled");
    wr(DATA, 16'h1234);
    rd(TXLVL, 16'd0, "R8 write while disabled dropped");
    eng_push(16'h5678);
    rd(RXLVL, 16'd0, "R8 push while disabled dropped");
    idle(1);
    check_bit(tx_dma_req, 1'b0, "R7 no tx dma when disabled");
    check_bit(rx_dma_req, 1'b0, "R7 no rx dma when disabled");
    wr(TXTHR, 9);
    rd(TXTHR, 16'd9, "R9 threshold writable when disabled");

    eng_busy = 1'b1; eng_tgt_busy = 1'b1;
    rd(STAT, 16'h002D, "R2 busy bits");

    idle(3);
    done = 1'b1;
    finish_run();
  end

endmodule